// File: doc/BRIEF.md
# Three-Format Instruction Decoder

This block turns one fixed-length 32-bit instruction word of a three-address load/store machine into the control and index signals a datapath needs. It pulls out the major opcode, the register fields and the extended opcode. It sign-extends the long address or the short displacement, and it classifies the word by format and addressing mode. It then raises exactly one bit of an operation select, or flags the word as illegal.

It is purely combinational. The surrounding pipeline registers the instruction word and consumes the outputs in the same stage. The register file, ALU, memory and sequencing logic lie outside it. Some mnemonics mean different things depending on where they sit. A load or an add can come from a major opcode or from the extended opcode under major opcode 31, and each placement carries its own format and addressing mode.

Top module: `tri_fmt_decoder`

## Requirements
- R1: `opcode_o` equals instruction bits [31:27] and `xop_o` equals bits [11:0] for every word. Register fields are rd1=[26:22], rs2=[21:17] and rs3=[16:12].
- R2: For major opcodes 0, 2, 3, 5 and 6 (long-address format), `imm_o` is bits [21:0] sign-extended from bit 21.
- R3: For major opcodes 1, 4 and 7..13 (displacement format), `imm_o` is bits [16:0] sign-extended from bit 16. For major opcode 31 and for illegal words, `imm_o` is zero.
- R4: `fmt_o` is 0 for long-address words (opcodes 0,2,3,5,6), 1 for displacement words (1,4,7..13), 2 for legal extended words, and 3 for illegal words. `amode_o` is 0 absolute (0,3,5,6), 1 displacement (1,4), 2 indexed (xop 9,10), 3 immediate (2,7..13), 4 register (xop 0..6), 5 two-operand register (xop 7,8), 6 special (xop 11,12), and 7 for illegal words.
- R5: `op_sel_o` has exactly one bit set for a legal word. Bit 0 add, 1 sub, 2 mul, 3 div, 4 and, 5 or, 6 xor, 7 shl, 8 shr, 9 load, 10 store, 11 jmp, 12 jal, 13 jr, 14 trap. Major opcodes 7..13 map in order to bits 0..6. Extended opcodes 0..8 map to bits 0..8, 9 to bit 9, 10 to bit 10, 11 to bit 13 and 12 to bit 14.
- R6: Major opcodes 14..30 and extended opcodes 13..4095 under major 31 set `illegal_o`. `op_sel_o`, `reg_we_o`, both memory strobes, `jump_o` and all index outputs are then zero.
- R7: `mem_rd_o` is high only for loads from memory (opcodes 0, 1 and xop 9). The immediate load (opcode 2) does not read memory. `mem_wr_o` is high only for stores (opcodes 3, 4 and xop 10).
- R8: `reg_we_o` is high for all loads, all ALU and shift operations and jal. It is low for stores, jmp, jr, trap and illegal words. `wr_idx_o` is rd1 when `reg_we_o` is high and zero otherwise.
- R9: `src_a_o` is rs2 for displacement loads and stores, for ALU-immediate operations and for every extended register, shift and indexed operation. It is rd1 for jr and zero otherwise. `src_b_o` is rs3 for extended register operations (xop 0..6) and indexed load and store, and zero otherwise. `src_data_o` is rd1 for all stores and zero otherwise.
- R10: `jump_o` is high for jmp, jal and jr only. `aux_o` carries rd1 for jmp (condition code) and trap (trap number), and is zero otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| insn_i | input | 32 | Registered instruction word |
| opcode_o | output | 5 | Major opcode field |
| xop_o | output | 12 | Extended opcode field |
| fmt_o | output | 2 | Format class |
| amode_o | output | 3 | Addressing mode |
| op_sel_o | output | 15 | One-hot operation select |
| illegal_o | output | 1 | Undefined major or extended opcode |
| imm_o | output | 32 | Sign-extended address or displacement |
| src_a_o | output | 5 | First read index (base or first operand) |
| src_b_o | output | 5 | Second read index (index or second operand) |
| src_data_o | output | 5 | Store data read index |
| wr_idx_o | output | 5 | Write-back index |
| reg_we_o | output | 1 | Register write enable |
| mem_rd_o | output | 1 | Memory read strobe |
| mem_wr_o | output | 1 | Memory write strobe |
| jump_o | output | 1 | Control transfer class |
| aux_o | output | 5 | Condition code or trap number |

## Verification
The bench sweeps every major opcode with boundary field patterns and every one of the 4096 extended opcodes. This covers the edges between defined and undefined codes: 13/14, 30/31 and xop 12/13. A decoder that got these edges wrong would execute garbage, or would trap a valid shift or jr. Address and displacement patterns sit at the most negative and the most positive values, so an extension taken from the wrong bit shows up as a wrong sign. The immediate load is checked for a missing memory read, and jr and stores for the rd1 field being routed to a read port rather than to the write port.

// File: rtl/tri_fmt_pkg.sv
package tri_fmt_pkg;

   localparam int NUM_OPS  = 15;

   localparam int SEL_ADD  = 0;
   localparam int SEL_SUB  = 1;
   localparam int SEL_MUL  = 2;
   localparam int SEL_DIV  = 3;
   localparam int SEL_AND  = 4;
   localparam int SEL_OR   = 5;
   localparam int SEL_XOR  = 6;
   localparam int SEL_SHL  = 7;
   localparam int SEL_SHR  = 8;
   localparam int SEL_LD   = 9;
   localparam int SEL_ST   = 10;
   localparam int SEL_JMP  = 11;
   localparam int SEL_JAL  = 12;
   localparam int SEL_JR   = 13;
   localparam int SEL_TRAP = 14;

   localparam int XOP_LAST = 12;

   typedef enum logic [1:0] {
      FMT_L    = 2'd0,
      FMT_D    = 2'd1,
      FMT_X    = 2'd2,
      FMT_NONE = 2'd3
   } fmt_e;

   typedef enum logic [2:0] {
      AM_ABS   = 3'd0,
      AM_DISP  = 3'd1,
      AM_INDEX = 3'd2,
      AM_IMM   = 3'd3,
      AM_REG   = 3'd4,
      AM_REG2  = 3'd5,
      AM_SPEC  = 3'd6,
      AM_NONE  = 3'd7
   } amode_e;

   typedef enum logic [1:0] {
      IMM_ZERO = 2'd0,
      IMM_ADDR = 2'd1,
      IMM_DISP = 2'd2
   } imm_src_e;

   typedef struct packed {
      fmt_e                 fmt;
      amode_e               amode;
      logic [NUM_OPS-1:0]   sel;
      logic                 illegal;
      imm_src_e             imm;
      logic                 rd_a;
      logic                 a_from_rd1;
      logic                 rd_b;
      logic                 rd_data;
      logic                 we;
      logic                 mrd;
      logic                 mwr;
      logic                 jump;
      logic                 aux;
   } dec_t;

   function automatic dec_t dec_illegal();
      dec_t d;
      d         = '0;
      d.fmt     = FMT_NONE;
      d.amode   = AM_NONE;
      d.imm     = IMM_ZERO;
      d.illegal = 1'b1;
      return d;
   endfunction

endpackage

// File: rtl/tri_fmt_fields.sv
module tri_fmt_fields #(
   parameter int WORD_W   = 32,
   parameter int OPC_W    = 5,
   parameter int REG_W    = 5,
   parameter int ADDR_W   = 22,
   parameter int DISP_W   = 17,
   parameter int XOP_W    = 12,
   parameter bit SIGN_EXT = 1'b1
) (
   input  logic [WORD_W-1:0] word_i,
   output logic [OPC_W-1:0]  opc_o,
   output logic [REG_W-1:0]  rd1_o,
   output logic [REG_W-1:0]  rs2_o,
   output logic [REG_W-1:0]  rs3_o,
   output logic [XOP_W-1:0]  xop_o,
   output logic [WORD_W-1:0] addr_ext_o,
   output logic [WORD_W-1:0] disp_ext_o
);

   localparam int OPC_LSB = WORD_W - OPC_W;
   localparam int RD1_LSB = OPC_LSB - REG_W;
   localparam int RS2_LSB = RD1_LSB - REG_W;
   localparam int RS3_LSB = RS2_LSB - REG_W;
   localparam int ADDR_PAD = WORD_W - ADDR_W;
   localparam int DISP_PAD = WORD_W - DISP_W;

   logic [ADDR_W-1:0] addr_raw;
   logic [DISP_W-1:0] disp_raw;

   assign opc_o    = word_i[WORD_W-1:OPC_LSB];
   assign rd1_o    = word_i[OPC_LSB-1:RD1_LSB];
   assign rs2_o    = word_i[RD1_LSB-1:RS2_LSB];
   assign rs3_o    = word_i[RS2_LSB-1:RS3_LSB];
   assign xop_o    = word_i[XOP_W-1:0];
   assign addr_raw = word_i[ADDR_W-1:0];
   assign disp_raw = word_i[DISP_W-1:0];

   generate
      if (SIGN_EXT) begin : g_sext
         assign addr_ext_o = {{ADDR_PAD{addr_raw[ADDR_W-1]}}, addr_raw};
         assign disp_ext_o = {{DISP_PAD{disp_raw[DISP_W-1]}}, disp_raw};
      end else begin : g_zext
         assign addr_ext_o = {{ADDR_PAD{1'b0}}, addr_raw};
         assign disp_ext_o = {{DISP_PAD{1'b0}}, disp_raw};
      end
   endgenerate

endmodule

// File: rtl/tri_fmt_major.sv
module tri_fmt_major
   import tri_fmt_pkg::*;
#(
   parameter int OPC_W = 5
) (
   input  logic [OPC_W-1:0] opc_i,
   output dec_t             dec_o
);

   dec_t d;

   always_comb begin
      d = dec_illegal();
      case (int'(opc_i))
         0, 1, 2: begin
            d.illegal     = 1'b0;
            d.sel[SEL_LD] = 1'b1;
            d.we          = 1'b1;
            if (int'(opc_i) == 1) begin
               d.fmt   = FMT_D;
               d.amode = AM_DISP;
               d.imm   = IMM_DISP;
               d.rd_a  = 1'b1;
               d.mrd   = 1'b1;
            end else begin
               d.fmt   = FMT_L;
               d.amode = (int'(opc_i) == 0) ? AM_ABS : AM_IMM;
               d.imm   = IMM_ADDR;
               d.mrd   = (int'(opc_i) == 0);
            end
         end
         3, 4: begin
            d.illegal     = 1'b0;
            d.sel[SEL_ST] = 1'b1;
            d.mwr         = 1'b1;
            d.rd_data     = 1'b1;
            if (int'(opc_i) == 4) begin
               d.fmt   = FMT_D;
               d.amode = AM_DISP;
               d.imm   = IMM_DISP;
               d.rd_a  = 1'b1;
            end else begin
               d.fmt   = FMT_L;
               d.amode = AM_ABS;
               d.imm   = IMM_ADDR;
            end
         end
         5: begin
            d.illegal      = 1'b0;
            d.fmt          = FMT_L;
            d.amode        = AM_ABS;
            d.imm          = IMM_ADDR;
            d.sel[SEL_JMP] = 1'b1;
            d.jump         = 1'b1;
            d.aux          = 1'b1;
         end
         6: begin
            d.illegal      = 1'b0;
            d.fmt          = FMT_L;
            d.amode        = AM_ABS;
            d.imm          = IMM_ADDR;
            d.sel[SEL_JAL] = 1'b1;
            d.jump         = 1'b1;
            d.we           = 1'b1;
         end
         7, 8, 9, 10, 11, 12, 13: begin
            d.illegal = 1'b0;
            d.fmt     = FMT_D;
            d.amode   = AM_IMM;
            d.imm     = IMM_DISP;
            d.rd_a    = 1'b1;
            d.we      = 1'b1;
            case (int'(opc_i))
               7:       d.sel[SEL_ADD] = 1'b1;
               8:       d.sel[SEL_SUB] = 1'b1;
               9:       d.sel[SEL_MUL] = 1'b1;
               10:      d.sel[SEL_DIV] = 1'b1;
               11:      d.sel[SEL_AND] = 1'b1;
               12:      d.sel[SEL_OR]  = 1'b1;
               default: d.sel[SEL_XOR] = 1'b1;
            endcase
         end
         default: d = dec_illegal();
      endcase
   end

   assign dec_o = d;

endmodule

// File: rtl/tri_fmt_ext.sv
module tri_fmt_ext
   import tri_fmt_pkg::*;
#(
   parameter int XOP_W = 12
) (
   input  logic [XOP_W-1:0] xop_i,
   output dec_t             dec_o
);

   dec_t d;
   int   x;

   always_comb begin
      x = int'(xop_i);
      d = dec_illegal();
      if (x <= XOP_LAST) begin
         d.illegal = 1'b0;
         d.fmt     = FMT_X;
         d.imm     = IMM_ZERO;
         if (x <= SEL_XOR) begin
            d.amode = AM_REG;
            d.sel[x] = 1'b1;
            d.rd_a  = 1'b1;
            d.rd_b  = 1'b1;
            d.we    = 1'b1;
         end else if (x == 7 || x == 8) begin
            d.amode = AM_REG2;
            d.sel[x] = 1'b1;
            d.rd_a  = 1'b1;
            d.we    = 1'b1;
         end else if (x == 9) begin
            d.amode       = AM_INDEX;
            d.sel[SEL_LD] = 1'b1;
            d.rd_a        = 1'b1;
            d.rd_b        = 1'b1;
            d.we          = 1'b1;
            d.mrd         = 1'b1;
         end else if (x == 10) begin
            d.amode       = AM_INDEX;
            d.sel[SEL_ST] = 1'b1;
            d.rd_a        = 1'b1;
            d.rd_b        = 1'b1;
            d.rd_data     = 1'b1;
            d.mwr         = 1'b1;
         end else if (x == 11) begin
            d.amode       = AM_SPEC;
            d.sel[SEL_JR] = 1'b1;
            d.rd_a        = 1'b1;
            d.a_from_rd1  = 1'b1;
            d.jump        = 1'b1;
         end else begin
            d.amode         = AM_SPEC;
            d.sel[SEL_TRAP] = 1'b1;
            d.aux           = 1'b1;
         end
      end
   end

   assign dec_o = d;

endmodule

// File: rtl/tri_fmt_decoder.sv
module tri_fmt_decoder
   import tri_fmt_pkg::*;
#(
   parameter int WORD_W   = 32,
   parameter int OPC_W    = 5,
   parameter int REG_W    = 5,
   parameter int ADDR_W   = 22,
   parameter int DISP_W   = 17,
   parameter int XOP_W    = 12,
   parameter bit SIGN_EXT = 1'b1
) (
   input  logic [WORD_W-1:0]  insn_i,
   output logic [OPC_W-1:0]   opcode_o,
   output logic [XOP_W-1:0]   xop_o,
   output logic [1:0]         fmt_o,
   output logic [2:0]         amode_o,
   output logic [NUM_OPS-1:0] op_sel_o,
   output logic               illegal_o,
   output logic [WORD_W-1:0]  imm_o,
   output logic [REG_W-1:0]   src_a_o,
   output logic [REG_W-1:0]   src_b_o,
   output logic [REG_W-1:0]   src_data_o,
   output logic [REG_W-1:0]   wr_idx_o,
   output logic               reg_we_o,
   output logic               mem_rd_o,
   output logic               mem_wr_o,
   output logic               jump_o,
   output logic [REG_W-1:0]   aux_o
);

   generate
      if (OPC_W + REG_W + ADDR_W != WORD_W) begin : g_bad_l
         $error("long-address format does not fill the word");
      end
      if (OPC_W + 2*REG_W + DISP_W != WORD_W) begin : g_bad_d
         $error("displacement format does not fill the word");
      end
      if (OPC_W + 3*REG_W + XOP_W != WORD_W) begin : g_bad_x
         $error("extended format does not fill the word");
      end
      if (OPC_W < 4 || XOP_W < 4) begin : g_bad_codes
         $error("opcode fields too narrow for the operation set");
      end
   endgenerate

   logic [REG_W-1:0]  rd1, rs2, rs3;
   logic [WORD_W-1:0] addr_ext, disp_ext;
   dec_t              dec_major, dec_ext, dec;
   logic              is_ext;

   tri_fmt_fields #(
      .WORD_W(WORD_W), .OPC_W(OPC_W), .REG_W(REG_W),
      .ADDR_W(ADDR_W), .DISP_W(DISP_W), .XOP_W(XOP_W),
      .SIGN_EXT(SIGN_EXT)
   ) u_fields (
      .word_i    (insn_i),
      .opc_o     (opcode_o),
      .rd1_o     (rd1),
      .rs2_o     (rs2),
      .rs3_o     (rs3),
      .xop_o     (xop_o),
      .addr_ext_o(addr_ext),
      .disp_ext_o(disp_ext)
   );

   tri_fmt_major #(.OPC_W(OPC_W)) u_major (
      .opc_i(opcode_o),
      .dec_o(dec_major)
   );

   tri_fmt_ext #(.XOP_W(XOP_W)) u_ext (
      .xop_i(xop_o),
      .dec_o(dec_ext)
   );

   assign is_ext = &opcode_o;
   assign dec    = is_ext ? dec_ext : dec_major;

   always_comb begin
      case (dec.imm)
         IMM_ADDR: imm_o = addr_ext;
         IMM_DISP: imm_o = disp_ext;
         default:  imm_o = '0;
      endcase
   end

   assign fmt_o      = dec.fmt;
   assign amode_o    = dec.amode;
   assign op_sel_o   = dec.sel;
   assign illegal_o  = dec.illegal;
   assign src_a_o    = dec.rd_a ? (dec.a_from_rd1 ? rd1 : rs2) : '0;
   assign src_b_o    = dec.rd_b ? rs3 : '0;
   assign src_data_o = dec.rd_data ? rd1 : '0;
   assign wr_idx_o   = dec.we ? rd1 : '0;
   assign reg_we_o   = dec.we;
   assign mem_rd_o   = dec.mrd;
   assign mem_wr_o   = dec.mwr;
   assign jump_o     = dec.jump;
   assign aux_o      = dec.aux ? rd1 : '0;

endmodule

// File: rtl/tri_fmt_decoder_chk.sv
module tri_fmt_decoder_chk #(
   parameter int WORD_W  = 32,
   parameter int REG_W   = 5,
   parameter int NUM_SEL = 15
) (
   input logic [1:0]         fmt_o,
   input logic [NUM_SEL-1:0] op_sel_o,
   input logic               illegal_o,
   input logic [WORD_W-1:0]  imm_o,
   input logic [REG_W-1:0]   wr_idx_o,
   input logic               reg_we_o,
   input logic               mem_rd_o,
   input logic               mem_wr_o,
   input logic               jump_o
);

   always_comb begin
      p_sel_onehot_r5: assert ($onehot0(op_sel_o))
         else $error("operation select has more than one bit");
      if (!illegal_o) begin
         p_legal_has_op_r5: assert ($countones(op_sel_o) == 1)
            else $error("legal word without an operation");
      end
      if (illegal_o) begin
         p_illegal_quiet_r6: assert (op_sel_o == '0 && !reg_we_o && !mem_rd_o
                                     && !mem_wr_o && !jump_o)
            else $error("illegal word drives a side effect");
      end
      p_mem_excl_r7: assert (!(mem_rd_o && mem_wr_o))
         else $error("read and write strobes together");
      if (mem_wr_o) begin
         p_store_nowrite_r8: assert (!reg_we_o)
            else $error("store enables register write");
      end
      if (!reg_we_o) begin
         p_widx_idle_r8: assert (wr_idx_o == '0)
            else $error("write index without write enable");
      end
      if (fmt_o == 2'd2) begin
         p_xfmt_imm_r3: assert (imm_o == '0)
            else $error("extended format carries an immediate");
      end
   end

endmodule

bind tri_fmt_decoder tri_fmt_decoder_chk #(
   .WORD_W (WORD_W),
   .REG_W  (REG_W),
   .NUM_SEL(tri_fmt_pkg::NUM_OPS)
) chk_i (
   .fmt_o    (fmt_o),
   .op_sel_o (op_sel_o),
   .illegal_o(illegal_o),
   .imm_o    (imm_o),
   .wr_idx_o (wr_idx_o),
   .reg_we_o (reg_we_o),
   .mem_rd_o (mem_rd_o),
   .mem_wr_o (mem_wr_o),
   .jump_o   (jump_o)
);

// File: tb/tri_fmt_decoder_tb_top.sv
module tri_fmt_decoder_tb_top;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [31:0] insn_d = '0;
   logic [31:0] insn_q;
   int          n_checks = 0;
   int          n_fails  = 0;
   bit          done = 1'b0;

   always #10 clk = ~clk;

   always_ff @(posedge clk) begin
      if (!rst_n) insn_q <= '0;
      else        insn_q <= insn_d;
   end

   logic [4:0]  opcode;
   logic [11:0] xop;
   logic [1:0]  fmt;
   logic [2:0]  amode;
   logic [14:0] op_sel;
   logic        illegal;
   logic [31:0] imm;
   logic [4:0]  src_a, src_b, src_data, wr_idx, aux;
   logic        reg_we, mem_rd, mem_wr, jump;

   tri_fmt_decoder dut_i (
      .insn_i(insn_q), .opcode_o(opcode), .xop_o(xop), .fmt_o(fmt),
      .amode_o(amode), .op_sel_o(op_sel), .illegal_o(illegal), .imm_o(imm),
      .src_a_o(src_a), .src_b_o(src_b), .src_data_o(src_data),
      .wr_idx_o(wr_idx), .reg_we_o(reg_we), .mem_rd_o(mem_rd),
      .mem_wr_o(mem_wr), .jump_o(jump), .aux_o(aux)
   );

   typedef struct packed {
      logic [1:0]  fmt;
      logic [2:0]  am;
      logic [14:0] sel;
      logic        ill;
      logic [31:0] imm;
      logic [4:0]  a, b, d, wi;
      logic        we, mr, mw, jp;
      logic [4:0]  aux;
   } exp_t;

   function automatic exp_t model(input logic [31:0] w);
      exp_t e;
      int op, xo;
      logic [4:0] r1, r2, r3;
      op = int'(w[31:27]);
      xo = int'(w[11:0]);
      r1 = w[26:22]; r2 = w[21:17]; r3 = w[16:12];
      e = '0;
      e.fmt = 2'd3; e.am = 3'd7; e.ill = 1'b1;
      if (op <= 13) begin
         e.ill = 1'b0;
         if (op == 0 || op == 2 || op == 3 || op == 5 || op == 6) begin
            e.fmt = 2'd0;
            e.imm = {{10{w[21]}}, w[21:0]};
         end else begin
            e.fmt = 2'd1;
            e.imm = {{15{w[16]}}, w[16:0]};
         end
         if (op == 0 || op == 3 || op == 5 || op == 6) e.am = 3'd0;
         else if (op == 1 || op == 4)                  e.am = 3'd1;
         else                                          e.am = 3'd3;
         if (op <= 2) begin e.sel[9] = 1'b1; e.we = 1'b1; end
         if (op == 0 || op == 1) e.mr = 1'b1;
         if (op == 1 || op == 4) e.a = r2;
         if (op == 3 || op == 4) begin e.sel[10] = 1'b1; e.mw = 1'b1; e.d = r1; end
         if (op == 5) begin e.sel[11] = 1'b1; e.jp = 1'b1; e.aux = r1; end
         if (op == 6) begin e.sel[12] = 1'b1; e.jp = 1'b1; e.we = 1'b1; end
         if (op >= 7) begin e.sel[op-7] = 1'b1; e.we = 1'b1; e.a = r2; end
      end else if (op == 31 && xo <= 12) begin
         e.ill = 1'b0; e.fmt = 2'd2;
         if (xo <= 6) begin
            e.am = 3'd4; e.sel[xo] = 1'b1; e.a = r2; e.b = r3; e.we = 1'b1;
         end else if (xo <= 8) begin
            e.am = 3'd5; e.sel[xo] = 1'b1; e.a = r2; e.we = 1'b1;
         end else if (xo == 9) begin
            e.am = 3'd2; e.sel[9] = 1'b1; e.a = r2; e.b = r3; e.we = 1'b1; e.mr = 1'b1;
         end else if (xo == 10) begin
            e.am = 3'd2; e.sel[10] = 1'b1; e.a = r2; e.b = r3; e.d = r1; e.mw = 1'b1;
         end else if (xo == 11) begin
            e.am = 3'd6; e.sel[13] = 1'b1; e.a = r1; e.jp = 1'b1;
         end else begin
            e.am = 3'd6; e.sel[14] = 1'b1; e.aux = r1;
         end
      end
      if (e.we) e.wi = r1;
      return e;
   endfunction

   task automatic chk(input bit ok, input string req, input string what,
                      input logic [63:0] act, input logic [63:0] exp_v,
                      input logic [31:0] w);
      n_checks++;
      if (!ok) begin
         n_fails++;
         $display("FAIL %s %s insn=%h actual=%h expected=%h", req, what, w, act, exp_v);
      end
   endtask

   task automatic compare(input logic [31:0] w);
      exp_t e;
      string rimm;
      e = model(w);
      rimm = (e.fmt == 2'd0) ? "R2" : "R3";
      chk(opcode == w[31:27] && xop == w[11:0], "R1", "fields",
          {opcode, xop}, {w[31:27], w[11:0]}, w);
      chk(imm == e.imm, rimm, "imm", imm, e.imm, w);
      chk(fmt == e.fmt && amode == e.am, "R4", "fmt/amode",
          {fmt, amode}, {e.fmt, e.am}, w);
      if (e.ill)
         chk(illegal && op_sel == '0 && src_a == '0 && src_b == '0 && src_data == '0,
             "R6", "illegal", {illegal, op_sel}, {e.ill, e.sel}, w);
      else
         chk(!illegal && op_sel == e.sel, "R5", "op_sel",
             {illegal, op_sel}, {e.ill, e.sel}, w);
      chk(mem_rd == e.mr && mem_wr == e.mw, "R7", "strobes",
          {mem_rd, mem_wr}, {e.mr, e.mw}, w);
      chk(reg_we == e.we && wr_idx == e.wi, "R8", "write",
          {reg_we, wr_idx}, {e.we, e.wi}, w);
      chk(src_a == e.a && src_b == e.b && src_data == e.d, "R9", "sources",
          {src_a, src_b, src_data}, {e.a, e.b, e.d}, w);
      chk(jump == e.jp && aux == e.aux, "R10", "jump/aux",
          {jump, aux}, {e.jp, e.aux}, w);
   endtask

   task automatic apply(input logic [31:0] w);
      insn_d = w;
      @(posedge clk);
      #5;
      compare(w);
   endtask

   logic [31:0] lfsr = 32'h1234_5678;

   function automatic logic [31:0] step(input logic [31:0] s);
      logic [31:0] t;
      t = s ^ (s << 13);
      t = t ^ (t >> 17);
      t = t ^ (t << 5);
      return t;
   endfunction

   initial begin
      repeat (3) @(posedge clk);
      #5;
      compare(32'h0);          // reset state: all-zero word held in the register
      rst_n = 1'b1;
      for (int op = 0; op < 31; op++) begin
         for (int k = 0; k < 16; k++) begin
            logic [26:0] body;
            lfsr = step(lfsr);
            case (k)
               0:       body = '0;
               1:       body = '1;
               2:       body = {5'd31, 22'h200000};
               3:       body = {5'd17, 22'h1FFFFF};
               4:       body = {5'd9, 5'd0, 17'h10000};
               5:       body = {5'd3, 5'd31, 17'h0FFFF};
               default: body = lfsr[26:0];
            endcase
            apply({op[4:0], body});
         end
      end
      for (int x = 0; x < 4096; x++) begin
         lfsr = step(lfsr);
         apply({5'd31, lfsr[26:12], x[11:0]});
      end
      for (int x = 0; x < 16; x++) begin
         apply({5'd31, 15'h7FFF, x[11:0]});
      end
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         n_fails++;
         $display("FAIL watchdog expired");
         $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
         $finish;
      end
   end

endmodule